// File: doc/BRIEF.md
# Brake Transition Supervisor for a Two-Bridge Reluctance Drive

This block supervises a four-phase switched reluctance drive whose phases are split over two independent bridges. Phases A and C sit on one bridge with a shared leg, and phases B and D sit on the other. In motoring it passes a single active phase, in forward firing order, to the per-phase switch logic. It keeps the dc-link regeneration switch off.

A brake command starts a fixed sequence. First every phase is switched on together, so the boost capacitors empty into the windings. Next every phase is held off while the currents decay. Only then is the regeneration switch enabled and the firing order reversed, so that excitation lands in the falling-inductance region. When the rotor reports standstill, the block drops all excitation and raises a request to disconnect the supply, so the machine cannot start turning backwards.

The discharge and decay steps each have a cycle-count limit given at the ports. The phase pointer moves only on an explicit step strobe. Switch timing, current regulation and sensing belong to other blocks.

Top module: `brake_supervisor`

## Requirements
- R1: A synchronous active-high reset sets mode to 0 (motoring), regen_en to 0, order_rev to 0 and supply_off to 0, and sets the phase pointer to A, so phase_en reads 4'b0001. Bit 0 of phase_en is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: In motoring (mode 0), regen_en is 0 and phase_en is one-hot. Each cycle with step high moves the pointer forward A, B, C, D, A after the next clock edge.
- R3: A brake_cmd seen at a clock edge in motoring gives mode 1 (discharge) after that edge, with phase_en = 4'b1111.
- R4: Discharge ends at the first edge where both boost_ok bits are high, or after exactly max(dis_limit,1) cycles in discharge, whichever comes first. It then goes to mode 2 (decay).
- R5: In decay, phase_en is 4'b0000. Decay moves to mode 3 (regeneration) at an edge where both boost_ok bits are high and either all four cur_zero bits are high or the decay step has lasted max(dec_limit,1) cycles.
- R6: In regeneration, regen_en and order_rev are 1, phase_en is one-hot, and each step moves the pointer in reverse order A, D, C, B, A.
- R7: Whenever phase_en is one-hot-driven (modes 0 and 3), the two phases of one bridge (A with C, B with D) are never both set.
- R8: standstill seen at an edge in regeneration gives mode 4 (rest): supply_off 1, regen_en 0, phase_en 4'b0000. Rest holds until reset, whatever brake_cmd and standstill do.
- R9: A brake_cmd that arrives in discharge or decay does not restart the step. The discharge still lasts exactly max(dis_limit,1) cycles.
- R10: step has no effect on the pointer in modes 1, 2 and 4. The next step in regeneration continues from the pointer held before.
- R11: regen_en never rises unless both boost_ok bits are high. With boost_ok low, decay holds mode 2 for any length of time, even with all currents zero and the decay limit exceeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brake_cmd | input | 1 | Brake request, sampled in motoring only |
| step | input | 1 | Advance phase pointer (modes 0 and 3) |
| cur_zero | input | 4 | Per-phase current-zero flags, bit 0 = A |
| boost_ok | input | 2 | Per-bridge boost capacitor discharged to source level |
| standstill | input | 1 | Rotor at rest |
| dis_limit | input | TW | Discharge step cycle limit |
| dec_limit | input | TW | Decay step cycle limit |
| mode | output | 3 | 0 motor, 1 discharge, 2 decay, 3 regeneration, 4 rest |
| regen_en | output | 1 | dc-link regeneration switch enable |
| order_rev | output | 1 | Reverse phase firing order |
| phase_en | output | 4 | Phase excitation enables, bit 0 = A |
| supply_off | output | 1 | Supply disconnect request |

## Verification
The bench builds the block with TW = 4, so the limit inputs span 0 to 15. The bench sweeps both limits from 0 through 5, which covers the zero-limit corner and exact dwell counts. A 20-cycle hold with boost_ok low runs past the largest limit, so it exercises timer saturation. The step sequence is short enough to wrap the pointer in both directions.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NPH = 4;
    localparam int NBR = 2;
    localparam int IW  = $clog2(NPH);

    typedef enum logic [2:0] {
        BM_MOTOR = 3'd0,
        BM_DISCH = 3'd1,
        BM_DECAY = 3'd2,
        BM_REGEN = 3'd3,
        BM_REST  = 3'd4
    } brk_mode_e;

    typedef struct packed {
        logic           regen;
        logic           rev;
        logic           disc;
        logic           all_on;
        logic           ring_on;
    } brk_ctl_t;

    function automatic brk_ctl_t mode_ctl(brk_mode_e m);
        brk_ctl_t c;
        c = '0;
        case (m)
            BM_MOTOR: c.ring_on = 1'b1;
            BM_DISCH: c.all_on  = 1'b1;
            BM_REGEN: begin
                c.ring_on = 1'b1;
                c.regen   = 1'b1;
                c.rev     = 1'b1;
            end
            BM_REST: begin
                c.rev  = 1'b1;
                c.disc = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic timed_mode(brk_mode_e m);
        return (m == BM_DISCH) || (m == BM_DECAY);
    endfunction

endpackage

// File: rtl/brk_step_timer.sv
module brk_step_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_nx;

    assign cnt_nx  = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    assign expired = cnt_nx >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt_nx[TW-1:0];
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit || cnt == '0)); // R4

endmodule

// File: rtl/brk_mode_fsm.sv
module brk_mode_fsm
    import brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      brake_cmd,
    input  logic      boost_all,
    input  logic      cur_all_zero,
    input  logic      standstill,
    input  logic      expired,
    output brk_mode_e state,
    output logic      restart
);
    brk_mode_e state_n;

    always_comb begin
        state_n = state;
        case (state)
            BM_MOTOR: if (brake_cmd)                  state_n = BM_DISCH;
            BM_DISCH: if (boost_all || expired)       state_n = BM_DECAY;
            BM_DECAY: if (boost_all && (cur_all_zero || expired))
                                                      state_n = BM_REGEN;
            BM_REGEN: if (standstill)                 state_n = BM_REST;
            BM_REST:                                  state_n = BM_REST;
            default:                                  state_n = BM_MOTOR;
        endcase
    end

    assign restart = (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) state <= BM_MOTOR;
        else     state <= state_n;
    end

    AST_REGEN_AFTER_BOOST: assert property (@(posedge clk) disable iff (rst)
        (state == BM_DECAY && !boost_all) |=> state != BM_REGEN); // R11

    AST_REST_STICKY: assert property (@(posedge clk) disable iff (rst)
        state == BM_REST |=> state == BM_REST); // R8

    AST_ORDERED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == BM_MOTOR) |=> (state == BM_MOTOR || state == BM_DISCH)); // R3

endmodule

// File: rtl/brk_phase_ring.sv
module brk_phase_ring
    import brk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          reverse,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            idx <= reverse ? IW'(idx - 1'b1) : IW'(idx + 1'b1);
        end
    end

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !reverse) |=> idx == IW'($past(idx) + 1'b1)); // R2

    AST_REV_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && reverse) |=> idx == IW'($past(idx) - 1'b1)); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(idx)); // R10

endmodule

// File: rtl/brake_supervisor.sv
module brake_supervisor
    import brk_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          brake_cmd,
    input  logic          step,
    input  logic [3:0]    cur_zero,
    input  logic [1:0]    boost_ok,
    input  logic          standstill,
    input  logic [TW-1:0] dis_limit,
    input  logic [TW-1:0] dec_limit,
    output logic [2:0]    mode,
    output logic          regen_en,
    output logic          order_rev,
    output logic [3:0]    phase_en,
    output logic          supply_off
);
    brk_mode_e     state;
    brk_ctl_t      ctl;
    logic          restart;
    logic          expired;
    logic [IW-1:0] idx;
    logic [NPH-1:0] ring_hot;
    logic [TW-1:0] cur_limit;

    brk_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .brake_cmd    (brake_cmd),
        .boost_all    (&boost_ok),
        .cur_all_zero (&cur_zero),
        .standstill   (standstill),
        .expired      (expired),
        .state        (state),
        .restart      (restart)
    );

    assign cur_limit = (state == BM_DECAY) ? dec_limit : dis_limit;

    brk_step_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (timed_mode(state)),
        .limit   (cur_limit),
        .expired (expired)
    );

    assign ctl = mode_ctl(state);

    brk_phase_ring u_ring (
        .clk     (clk),
        .rst     (rst),
        .advance (step && ctl.ring_on),
        .reverse (ctl.rev),
        .idx     (idx)
    );

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_hot
            assign ring_hot[p] = (idx == IW'(p));
        end
    endgenerate

    always_comb begin
        if (ctl.all_on)       phase_en = '1;
        else if (ctl.ring_on) phase_en = ring_hot;
        else                  phase_en = '0;
    end

    assign mode       = state;
    assign regen_en   = ctl.regen;
    assign order_rev  = ctl.rev;
    assign supply_off = ctl.disc;

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode == 3'd3) |->
            !(phase_en[0] && phase_en[2]) && !(phase_en[1] && phase_en[3])); // R7

    AST_REGEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(regen_en) |-> $past(mode) == 3'd2); // R11

    AST_MOTOR_NO_REGEN: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd0 |-> !regen_en && !order_rev); // R2

    AST_DECAY_DARK: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 || mode == 3'd4) |-> phase_en == 4'b0000); // R5

endmodule

// File: tb/tb_brake_supervisor.sv
module tb_brake_supervisor;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          brake_cmd, step, standstill;
    logic [3:0]    cur_zero;
    logic [1:0]    boost_ok;
    logic [TW-1:0] dis_limit, dec_limit;
    logic [2:0]    mode;
    logic          regen_en, order_rev, supply_off;
    logic [3:0]    phase_en;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_idx;
    bit finished = 0;

    always #5 clk = ~clk;

    brake_supervisor #(.TW(TW)) dut (
        .clk(clk), .rst(rst), .brake_cmd(brake_cmd), .step(step),
        .cur_zero(cur_zero), .boost_ok(boost_ok), .standstill(standstill),
        .dis_limit(dis_limit), .dec_limit(dec_limit), .mode(mode),
        .regen_en(regen_en), .order_rev(order_rev), .phase_en(phase_en),
        .supply_off(supply_off)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; brake_cmd = 0; step = 0; standstill = 0;
        cur_zero = 4'b0000; boost_ok = 2'b00;
        tick(); tick();
        rst = 1'b0;
        exp_idx = 0;
    endtask

    function automatic int hot(int i);
        return 1 << i;
    endfunction

    task automatic step_once(bit rev, string req);
        step = 1; tick(); step = 0;
        exp_idx = rev ? (exp_idx + 3) % 4 : (exp_idx + 1) % 4;
        check(req, phase_en, hot(exp_idx));
    endtask

    int n;
    int dwell;

    initial begin
        dis_limit = '0; dec_limit = '0;
        do_reset();
        // R1
        check("R1 mode", mode, 0);
        check("R1 regen_en", regen_en, 0);
        check("R1 order_rev", order_rev, 0);
        check("R1 supply_off", supply_off, 0);
        check("R1 phase_en", phase_en, 1);

        // R2 / R7 forward order with wrap
        for (int k = 0; k < 6; k++) begin
            step_once(0, "R2 fwd");
            check("R7 pair", (phase_en[0] & phase_en[2]) | (phase_en[1] & phase_en[3]), 0);
            check("R2 regen off", regen_en, 0);
        end

        // R4 / R9 discharge dwell sweep, boost low
        for (int L = 0; L <= 5; L++) begin
            do_reset();
            dis_limit = TW'(L);
            brake_cmd = 1; tick(); brake_cmd = 0;
            check("R3 mode", mode, 1);
            check("R3 all on", phase_en, 15);
            n = 0;
            while (mode == 3'd1 && n < 40) begin
                brake_cmd = (L >= 3 && n == 1);
                tick();
                n++;
            end
            brake_cmd = 0;
            dwell = (L < 1) ? 1 : L;
            check(L >= 3 ? "R9 dwell" : "R4 dwell", n, dwell);
            check("R5 decay mode", mode, 2);
            check("R5 dark", phase_en, 0);
        end

        // R4 early exit on boost; R5 decay sweep; R6, R10, R8
        for (int D = 0; D <= 5; D++) begin
            do_reset();
            step_once(0, "R2 pre");
            dis_limit = 4'd9; dec_limit = TW'(D);
            boost_ok = 2'b11; cur_zero = 4'b0000;
            brake_cmd = 1; tick(); brake_cmd = 0;
            check("R3 mode", mode, 1);
            tick();
            check("R4 boost exit", mode, 2);
            n = 0;
            while (mode == 3'd2 && n < 40) begin
                step = 1; // R10: must not move pointer
                tick();
                n++;
            end
            step = 0;
            check("R5 decay dwell", n, (D < 1) ? 1 : D);
            check("R6 mode", mode, 3);
            check("R6 regen_en", regen_en, 1);
            check("R6 order_rev", order_rev, 1);
            check("R10 held ptr", phase_en, hot(exp_idx));
            for (int k = 0; k < 5; k++) begin
                step_once(1, "R6 rev");
                check("R7 pair", (phase_en[0] & phase_en[2]) | (phase_en[1] & phase_en[3]), 0);
            end
            standstill = 1; tick(); standstill = 0;
            check("R8 mode", mode, 4);
            check("R8 supply_off", supply_off, 1);
            check("R8 regen off", regen_en, 0);
            check("R8 dark", phase_en, 0);
        end

        // R8 rest held
        for (int k = 0; k < 10; k++) begin
            brake_cmd = k[0]; standstill = ~k[0]; step = 1;
            tick();
        end
        brake_cmd = 0; standstill = 0; step = 0;
        check("R8 hold", mode, 4);
        check("R8 hold off", supply_off, 1);

        // R5 current-zero early exit
        do_reset();
        dis_limit = 4'd2; dec_limit = 4'd9; boost_ok = 2'b11; cur_zero = 4'b1111;
        brake_cmd = 1; tick(); brake_cmd = 0;
        tick();
        check("R5 entered decay", mode, 2);
        tick();
        check("R5 zero exit", mode, 3);

        // R11 boost low blocks regeneration
        do_reset();
        dis_limit = 4'd2; dec_limit = 4'd1; boost_ok = 2'b01; cur_zero = 4'b1111;
        brake_cmd = 1; tick(); brake_cmd = 0;
        tick(); tick();
        check("R11 in decay", mode, 2);
        for (int k = 0; k < 20; k++) tick();
        check("R11 still decay", mode, 2);
        check("R11 regen off", regen_en, 0);
        boost_ok = 2'b11;
        tick();
        check("R11 released", mode, 3);
        check("R11 regen on", regen_en, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule